// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block times the individual bus phases of an I2C master. A sequencer asks for one phase at a time: it pulses a start strobe together with a phase code. The block then counts the programmed duration of that phase and returns a single-cycle completion pulse. The phases are start setup, start hold, stop setup, data setup, data hold, SCL low, SCL high and repeated-start release. All durations are measured in ticks of an internal prescaler that divides the system clock by DIV+1.

Two complete sets of timing words exist, one for fast mode and one for high-speed mode. A bit of the configuration word picks which set is used. The data-hold word is shared by both modes. The SCL low and SCL high phases carry a fixed overhead of four system clocks each, and the high phase also absorbs a glitch-filter delay of k·FLT clocks. A full low+high bus period therefore equals (DIV+1)·(L+H+2) + 8 + k·FLT. The parameter FLT_MULT sets k to 1 or 2. Tick counting in the high phase begins only once SCL is seen high, so a target that stretches the clock lengthens that phase cycle for cycle. Timing words are captured when a phase is accepted, so edits made while a phase runs never alter it.

Top module: `sclt_timing_gen`

## Requirements
- R1: While rst_ni is low and after it is released with no start, busy_o and done_o are 0.
- R2: A start_i pulse while busy_o is 0 is accepted, and busy_o is 1 in the following cycle. A start_i pulse while busy_o is 1 has no effect: it does not change the running phase's end, its reported code, or cause a later completion.
- R3: For phase codes 0 (start setup, word1[31:24]), 1 (start hold, word1[23:16]), 2 (stop setup, word1[15:8]), 3 (data setup, word2[31:24]), 4 (data hold, shared hold word [7:0]) and 7 (repeated-start release, word3[7:0]), done_o rises (DIV+1)·(N+1) clock edges after the accepting edge. DIV is word3[23:16] and N is the selected field.
- R4: For phase code 5 (SCL low, word2[15:8] = L), done_o rises (DIV+1)·(L+1)+4 edges after the accepting edge. FLT does not affect it.
- R5: For phase code 6 (SCL high, word2[7:0] = H), done_o rises (DIV+1)·(H+1)+4+k·FLT edges after the accepting edge when scl_i is high. FLT is cfg[18:16] and k = FLT_MULT (default 2). Each edge at which scl_i is sampled low before the first high sample adds one edge.
- R6: An SCL low phase followed by an SCL high phase with the same settings lasts (DIV+1)·(L+H+2)+8+k·FLT clocks in total.
- R7: cfg[29] = 1 selects the high-speed words, and cfg[29] = 0 selects the fast-mode words. The hold word is used in both modes.
- R8: Changes to any timing or configuration input while busy_o is 1 do not affect the running phase. The next accepted phase uses the new values.
- R9: done_o is high for exactly one cycle, and busy_o is 0 in that cycle. done_phase_o carries the accepted phase code from the cycle after acceptance until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Configuration: [29] high-speed select, [18:16] filter delay |
| fs_w1_i | input | 32 | Fast-mode start/stop timing word |
| fs_w2_i | input | 32 | Fast-mode data setup / SCL low / SCL high word |
| fs_w3_i | input | 32 | Fast-mode divider and repeated-start release word |
| hs_w1_i | input | 32 | High-speed start/stop timing word |
| hs_w2_i | input | 32 | High-speed data setup / SCL low / SCL high word |
| hs_w3_i | input | 32 | High-speed divider and repeated-start release word |
| hold_w_i | input | 32 | Shared data-hold word, field [7:0] |
| start_i | input | 1 | Phase request strobe |
| phase_i | input | 3 | Phase code of the request |
| scl_i | input | 1 | Sampled SCL line level |
| busy_o | output | 1 | A phase is running |
| done_o | output | 1 | One-cycle pulse at the end of a phase |
| done_phase_o | output | 3 | Code of the accepted phase |

## Verification
The hardest situation to reach is a running phase that sees a second event: a target holding SCL low, a second strobe, or timing words rewritten mid-count. The plain request/complete pattern never produces one. The bench's measurement task injects an event at a chosen edge count inside the running phase: it releases scl_i, pulses start_i with another code, or rewrites the divider and field. It then compares the completion edge with the value the formula predicts for unchanged settings. Fields that are not under test are filled with a distinct value, so a wrong field or a wrong register set gives a different duration.

// File: rtl/sclt_pkg.sv
package sclt_pkg;

  typedef enum logic [2:0] {
    PH_STA_SU = 3'd0,
    PH_STA_HD = 3'd1,
    PH_STO_SU = 3'd2,
    PH_DAT_SU = 3'd3,
    PH_DAT_HD = 3'd4,
    PH_SCL_LO = 3'd5,
    PH_SCL_HI = 3'd6,
    PH_SR_REL = 3'd7
  } phase_e;

  typedef struct packed {
    logic [31:0] w1;
    logic [31:0] w2;
    logic [31:0] w3;
  } tset_t;

  // field positions decoded by the bus sequencer's register file
  localparam int unsigned CFG_HS_BIT  = 29;
  localparam int unsigned CFG_FLT_LSB = 16;
  localparam int unsigned W1_STA_SU   = 24;
  localparam int unsigned W1_STA_HD   = 16;
  localparam int unsigned W1_STO_SU   = 8;
  localparam int unsigned W2_DAT_SU   = 24;
  localparam int unsigned W2_SCL_LO   = 8;
  localparam int unsigned W2_SCL_HI   = 0;
  localparam int unsigned W3_DIV      = 16;
  localparam int unsigned W3_SR_REL   = 0;
  localparam int unsigned HOLD_LSB    = 0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_OVH,
    ST_COUNT
  } ctrl_st_e;

endpackage

// File: rtl/sclt_field_sel.sv
module sclt_field_sel
  import sclt_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned FLT_W    = 3,
  parameter int unsigned FLT_MULT = 2,
  parameter int unsigned SIDE_OVH = 4,
  parameter int unsigned OVH_W    = 5
) (
  input  logic [31:0]      cfg_i,
  input  tset_t            fs_i,
  input  tset_t            hs_i,
  input  logic [31:0]      hold_w_i,
  input  logic [2:0]       phase_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [DIV_W-1:0] div_o,
  output logic [OVH_W-1:0] extra_o,
  output logic             wait_hi_o
);

  tset_t             sel;
  logic [FLT_W-1:0]  flt;
  logic [OVH_W-1:0]  flt_ovh;

  assign sel = cfg_i[CFG_HS_BIT] ? hs_i : fs_i;
  assign flt = cfg_i[CFG_FLT_LSB +: FLT_W];

  generate
    if (FLT_MULT == 2) begin : g_flt_dbl
      assign flt_ovh = OVH_W'({flt, 1'b0});
    end else if (FLT_MULT == 1) begin : g_flt_single
      assign flt_ovh = OVH_W'(flt);
    end else begin : g_flt_mul
      assign flt_ovh = OVH_W'(flt) * OVH_W'(FLT_MULT);
    end
  endgenerate

  assign div_o = sel.w3[W3_DIV +: DIV_W];

  always_comb begin
    cnt_o     = '0;
    extra_o   = '0;
    wait_hi_o = 1'b0;
    unique case (phase_e'(phase_i))
      PH_STA_SU: cnt_o = sel.w1[W1_STA_SU +: CNT_W];
      PH_STA_HD: cnt_o = sel.w1[W1_STA_HD +: CNT_W];
      PH_STO_SU: cnt_o = sel.w1[W1_STO_SU +: CNT_W];
      PH_DAT_SU: cnt_o = sel.w2[W2_DAT_SU +: CNT_W];
      PH_DAT_HD: cnt_o = hold_w_i[HOLD_LSB +: CNT_W];
      PH_SCL_LO: begin
        cnt_o   = sel.w2[W2_SCL_LO +: CNT_W];
        extra_o = OVH_W'(SIDE_OVH);
      end
      PH_SCL_HI: begin
        cnt_o     = sel.w2[W2_SCL_HI +: CNT_W];
        extra_o   = OVH_W'(SIDE_OVH) + flt_ovh;
        wait_hi_o = 1'b1;
      end
      PH_SR_REL: cnt_o = sel.w3[W3_SR_REL +: CNT_W];
      default:   cnt_o = '0;
    endcase
  end

endmodule

// File: rtl/sclt_prescaler.sv
module sclt_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] pre_q;
  logic             wrap;

  assign wrap   = (pre_q == div_i);
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (!en_i)     pre_q <= '0;
    else if (wrap)      pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/sclt_phase_ctrl.sv
module sclt_phase_ctrl
  import sclt_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OVH_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       phase_i,
  input  logic             scl_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [OVH_W-1:0] extra_i,
  input  logic             wait_hi_i,
  input  logic             tick_i,
  output logic             count_en_o,
  output logic [DIV_W-1:0] div_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       phase_o
);

  ctrl_st_e         st_q;
  logic [CNT_W-1:0] left_q;
  logic [OVH_W-1:0] ovh_q;
  logic [OVH_W-1:0] extra_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       phase_q;
  logic             done_q;
  logic             accept;
  logic             last_tick;

  assign accept     = start_i && (st_q == ST_IDLE);
  assign count_en_o = (st_q == ST_COUNT);
  assign last_tick  = count_en_o && tick_i && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      left_q  <= '0;
      ovh_q   <= '0;
      extra_q <= '0;
      div_q   <= '0;
      phase_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_tick;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          // snapshot of the timing set: later edits cannot leak in
          left_q  <= cnt_i;
          div_q   <= div_i;
          extra_q <= extra_i;
          phase_q <= phase_i;
          ovh_q   <= extra_i;
          if (wait_hi_i)             st_q <= ST_WAIT_HI;
          else if (extra_i != '0)    st_q <= ST_OVH;
          else                       st_q <= ST_COUNT;
        end
        ST_WAIT_HI: if (scl_i) begin
          // this cycle already spends one overhead clock
          ovh_q <= extra_q - 1'b1;
          st_q  <= (extra_q > OVH_W'(1)) ? ST_OVH : ST_COUNT;
        end
        ST_OVH: begin
          if (ovh_q <= OVH_W'(1)) st_q <= ST_COUNT;
          else                    ovh_q <= ovh_q - 1'b1;
        end
        ST_COUNT: if (tick_i) begin
          if (left_q == '0) st_q <= ST_IDLE;
          else              left_q <= left_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign div_o   = div_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/sclt_timing_gen.sv
module sclt_timing_gen
  import sclt_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned FLT_W    = 3,
  parameter int unsigned FLT_MULT = 2,
  parameter int unsigned SIDE_OVH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] cfg_i,
  input  logic [31:0] fs_w1_i,
  input  logic [31:0] fs_w2_i,
  input  logic [31:0] fs_w3_i,
  input  logic [31:0] hs_w1_i,
  input  logic [31:0] hs_w2_i,
  input  logic [31:0] hs_w3_i,
  input  logic [31:0] hold_w_i,
  input  logic        start_i,
  input  logic [2:0]  phase_i,
  input  logic        scl_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [2:0]  done_phase_o
);

  localparam int unsigned EXTRA_MAX = SIDE_OVH + FLT_MULT * ((1 << FLT_W) - 1);
  localparam int unsigned OVH_W     = $clog2(EXTRA_MAX + 1);

  tset_t            fs_set;
  tset_t            hs_set;
  logic [CNT_W-1:0] sel_cnt;
  logic [DIV_W-1:0] sel_div;
  logic [OVH_W-1:0] sel_extra;
  logic             sel_wait_hi;
  logic [DIV_W-1:0] run_div;
  logic             count_en;
  logic             tick;

  assign fs_set = '{w1: fs_w1_i, w2: fs_w2_i, w3: fs_w3_i};
  assign hs_set = '{w1: hs_w1_i, w2: hs_w2_i, w3: hs_w3_i};

  sclt_field_sel #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .FLT_W(FLT_W),
    .FLT_MULT(FLT_MULT), .SIDE_OVH(SIDE_OVH), .OVH_W(OVH_W)
  ) u_sel (
    .cfg_i     (cfg_i),
    .fs_i      (fs_set),
    .hs_i      (hs_set),
    .hold_w_i  (hold_w_i),
    .phase_i   (phase_i),
    .cnt_o     (sel_cnt),
    .div_o     (sel_div),
    .extra_o   (sel_extra),
    .wait_hi_o (sel_wait_hi)
  );

  sclt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (count_en),
    .div_i  (run_div),
    .tick_o (tick)
  );

  sclt_phase_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W), .OVH_W(OVH_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .phase_i    (phase_i),
    .scl_i      (scl_i),
    .cnt_i      (sel_cnt),
    .div_i      (sel_div),
    .extra_i    (sel_extra),
    .wait_hi_i  (sel_wait_hi),
    .tick_i     (tick),
    .count_en_o (count_en),
    .div_o      (run_div),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .phase_o    (done_phase_o)
  );

endmodule

// File: rtl/sclt_timing_gen_chk.sv
module sclt_timing_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [2:0] phase_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] done_phase_o
);

  AST_START_ACCEPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> $stable(done_phase_o)); // R2

  AST_CODE_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (done_phase_o == $past(phase_i))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!busy_o && $past(busy_o))); // R9

endmodule

bind sclt_timing_gen sclt_timing_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .phase_i      (phase_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .done_phase_o (done_phase_o)
);

// File: tb/sim_sclt_timing_gen.sv
`timescale 1ns/1ps
module sim_sclt_timing_gen;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cfg_i = '0;
  logic [31:0] fs_w1_i = '0, fs_w2_i = '0, fs_w3_i = '0;
  logic [31:0] hs_w1_i = '0, hs_w2_i = '0, hs_w3_i = '0;
  logic [31:0] hold_w_i = '0;
  logic        start_i = 1'b0;
  logic [2:0]  phase_i = '0;
  logic        scl_i = 1'b1;
  logic        busy_o, done_o;
  logic [2:0]  done_phase_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [7:0] FILL = 8'd60;
  localparam int NV = 12;
  // {phase, hs, div, field, flt, expected edges}
  localparam logic [47:0] VEC [NV] = '{
    {4'd0, 4'd0, 8'd0,   8'd0,   8'd0, 16'd1},
    {4'd1, 4'd0, 8'd2,   8'd4,   8'd0, 16'd15},
    {4'd2, 4'd1, 8'd1,   8'd7,   8'd0, 16'd16},
    {4'd3, 4'd0, 8'd3,   8'd2,   8'd0, 16'd12},
    {4'd4, 4'd1, 8'd0,   8'd9,   8'd0, 16'd10},
    {4'd5, 4'd0, 8'd1,   8'd5,   8'd3, 16'd16},
    {4'd6, 4'd0, 8'd1,   8'd5,   8'd3, 16'd22},
    {4'd7, 4'd1, 8'd4,   8'd1,   8'd0, 16'd10},
    {4'd6, 4'd1, 8'd0,   8'd0,   8'd7, 16'd19},
    {4'd5, 4'd1, 8'd2,   8'd0,   8'd0, 16'd7},
    {4'd6, 4'd0, 8'd0,   8'd255, 8'd0, 16'd260},
    {4'd1, 4'd0, 8'd255, 8'd0,   8'd0, 16'd256}
  };

  sclt_timing_gen u0 (
    .clk_i, .rst_ni, .cfg_i, .fs_w1_i, .fs_w2_i, .fs_w3_i,
    .hs_w1_i, .hs_w2_i, .hs_w3_i, .hold_w_i, .start_i, .phase_i,
    .scl_i, .busy_o, .done_o, .done_phase_o
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_regs(input int ph, input bit hs, input logic [7:0] dv,
                          input logic [7:0] val, input logic [2:0] flt);
    logic [31:0] w1, w2, w3, dh, o3;
    w1 = {FILL, FILL, FILL, 8'h00};
    w2 = {FILL, 8'h00, FILL, FILL};
    w3 = {8'h00, dv, 8'h00, FILL};
    o3 = {8'h00, FILL, 8'h00, FILL};
    dh = {24'h0, FILL};
    case (ph)
      0: w1[31:24] = val;
      1: w1[23:16] = val;
      2: w1[15:8]  = val;
      3: w2[31:24] = val;
      4: dh[7:0]   = val;
      5: w2[15:8]  = val;
      6: w2[7:0]   = val;
      default: w3[7:0] = val;
    endcase
    cfg_i = '0;
    cfg_i[29] = hs;
    cfg_i[18:16] = flt;
    hold_w_i = dh;
    if (hs) begin
      hs_w1_i = w1; hs_w2_i = w2; hs_w3_i = w3;
      fs_w1_i = {FILL, FILL, FILL, 8'h00}; fs_w2_i = {FILL, 8'h00, FILL, FILL}; fs_w3_i = o3;
    end else begin
      fs_w1_i = w1; fs_w2_i = w2; fs_w3_i = w3;
      hs_w1_i = {FILL, FILL, FILL, 8'h00}; hs_w2_i = {FILL, 8'h00, FILL, FILL}; hs_w3_i = o3;
    end
  endtask

  // act: 0 none, 1 raise scl at edge n, 2 rewrite fast regs at n, 3 second start at n
  task automatic run_phase(input int ph, input int act, input int at, output int d);
    int cnt;
    @(negedge clk_i);
    start_i = 1'b1;
    phase_i = 3'(ph);
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    cnt = 0;
    d = -1;
    while (cnt < 30000) begin
      @(posedge clk_i);
      cnt++;
      @(negedge clk_i);
      if (start_i) start_i = 1'b0;
      if (done_o) begin
        d = cnt;
        break;
      end
      if (cnt == at) begin
        if (act == 1) scl_i = 1'b1;
        if (act == 2) begin fs_w2_i = '0; fs_w3_i = '0; end
        if (act == 3) begin start_i = 1'b1; phase_i = 3'd0; end
      end
    end
  endtask

  initial begin
    #(1600000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int d;
    int lo_d;
    bit quiet;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 in reset", {busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 after reset", {busy_o, done_o}, 0);

    // R3 R4 R5 R7 table walk
    for (int i = 0; i < NV; i++) begin
      set_regs(int'(VEC[i][47:44]), VEC[i][40], VEC[i][39:32], VEC[i][31:24], VEC[i][18:16]);
      run_phase(int'(VEC[i][47:44]), 0, 0, d);
      chk(d == int'(VEC[i][15:0]), $sformatf("R3/R4/R5/R7 vector %0d duration", i),
          d, int'(VEC[i][15:0]));
      chk(done_phase_o == VEC[i][46:44], $sformatf("R9 vector %0d code", i),
          done_phase_o, VEC[i][46:44]);
      @(negedge clk_i);
      chk(done_o == 1'b0 && busy_o == 1'b0, "R9 pulse width", done_o, 0);
    end

    // R5 clock stretching: scl low for 7 sampled edges
    set_regs(6, 1'b0, 8'd0, 8'd2, 3'd1);
    scl_i = 1'b0;
    run_phase(6, 1, 7, d);
    chk(d == 16, "R5 stretched high", d, 16);
    scl_i = 1'b1;

    // R6 full period, div 2, L 3, H 4, flt 2
    set_regs(5, 1'b0, 8'd2, 8'd3, 3'd2);
    fs_w2_i[7:0] = 8'd4;
    run_phase(5, 0, 0, lo_d);
    run_phase(6, 0, 0, d);
    chk(lo_d + d == 39, "R6 low+high period", lo_d + d, 39);

    // R2 second start while busy is ignored
    set_regs(1, 1'b0, 8'd2, 8'd4, 3'd0);
    run_phase(1, 3, 5, d);
    chk(d == 15, "R2 end unchanged", d, 15);
    chk(done_phase_o == 3'd1, "R2 code unchanged", done_phase_o, 1);
    quiet = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (done_o || busy_o) quiet = 1'b0;
    end
    chk(quiet, "R2 no extra completion", !quiet, 0);

    // R8 mid-phase register edits
    set_regs(3, 1'b0, 8'd3, 8'd2, 3'd0);
    run_phase(3, 2, 3, d);
    chk(d == 12, "R8 running phase unaffected", d, 12);
    run_phase(3, 0, 0, d);
    chk(d == 1, "R8 next phase uses new values", d, 1);

    // R7 same words, mode flipped: fast set has div FILL
    set_regs(7, 1'b1, 8'd0, 8'd3, 3'd0);
    cfg_i[29] = 1'b0;
    run_phase(7, 0, 0, d);
    chk(d == 61 * 61, "R7 fast set selected", d, 61 * 61);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule